// File: doc/BRIEF.md
# Translation Address Range Checker

This block screens a 64-bit address before a page-table walk is launched. It applies one of two legality rules, picked by a stage select. For a first-stage (virtual) address, every bit above the translated span must copy the span's top bit, which is a sign-extension test. For a second-stage (guest physical) address, the span is two bits wider and every bit above it must be zero. The span depends on the paging mode: 12 offset bits plus 9 bits for each table level, plus 2 more bits for second stage.

A request is accepted when `req_valid` and `req_ready` are both high. One cycle later the block presents a registered verdict with `rsp_valid`. The verdict holds the fault flag and the fault class. `req_ready` stays low while a verdict is waiting for `rsp_ready`.

Top module: `xlat_range_chk`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge produces `rsp_valid`=1 on the next edge. The response then holds stable until `rsp_ready` is seen high. While a response is pending, `req_ready` is 0.
- R3: First stage, mode 3'd1 (39-bit span): the address is legal only if bits 63..39 all equal bit 38. Otherwise the result has fault=1 and type 2'b01 (page fault).
- R4: First stage, mode 3'd2 (48-bit span) and mode 3'd3 (57-bit span): bits 63 and down must all equal bit 47 and bit 56 respectively. Otherwise the result is a page fault (type 2'b01).
- R5: Second stage (stage=1), mode 3'd1: bits 63..41 must be zero. Otherwise the result has fault=1 and type 2'b10 (guest-page fault). For example, 0xFFFF_FFFF_FF01_0000 faults under this rule.
- R6: Second stage, mode 3'd2 requires bits 63..50 to be zero, and mode 3'd3 requires bits 63..59 to be zero. Otherwise the result is a guest-page fault.
- R7: Mode 3'd0 (32-bit mode) always passes, in either stage.
- R8: The low 12 bits of the address never change the verdict.
- R9: Mode codes 3'd4..3'd7 always fault. The type is 2'b01 for first stage and 2'b10 for second stage.
- R10: When there is no fault, the type is 2'b00, and `rsp_fault` is 1 exactly when the type is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | Address to screen |
| req_stage2 | input | 1 | 0 = first stage, 1 = second stage |
| req_mode | input | 3 | 0 = 32-bit mode, 1/2/3 = 3/4/5 levels, others undefined |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict consumed |
| rsp_fault | output | 1 | Address illegal |
| rsp_kind | output | 2 | 00 none, 01 page fault, 10 guest-page fault |

## Verification
The bench aims at the boundary bit of each span. It flips the single bit just above the span, and it also flips the top bit inside the span. A design with an off-by-one span width would misjudge one of these addresses. It also sends all-ones upper addresses in second stage, which a design reusing the sign test would wrongly pass. It sends 32-bit mode with garbage upper bits, and undefined modes in both stages, which exposes a wrong fault class. Finally, it holds `rsp_ready` low for several cycles to catch a design that drops or overwrites a pending verdict.

// File: rtl/xlat_chk_pkg.sv
// Shared types and constants for the translation range checker.
// Assumes 4 KiB pages and 9 index bits per table level.
package xlat_chk_pkg;
    localparam int ADDR_W   = 64;
    localparam int PG_SHIFT = 12;
    localparam int IDX_W    = 9;
    localparam int WIDEN_W  = 2;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_PAGE  = 2'b01,
        FK_GUEST = 2'b10
    } fault_kind_e;

    typedef enum logic [2:0] {
        MD_BARE32 = 3'd0,
        MD_L3     = 3'd1,
        MD_L4     = 3'd2,
        MD_L5     = 3'd3
    } xlat_mode_e;
endpackage

// File: rtl/xlat_span_chk.sv
// Checks one fixed span width: sign-extension legality for first stage,
// zero upper bits for the two-bit-wider second stage span.
// Assumes LEVELS*IDX_W+PG_SHIFT+WIDEN_W < ADDR_W.
module xlat_span_chk
    import xlat_chk_pkg::*;
#(
    parameter int LEVELS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              s1_ok,
    output logic              s2_ok
);
    localparam int S1_W = PG_SHIFT + LEVELS * IDX_W;
    localparam int S2_W = S1_W + WIDEN_W;

    logic [ADDR_W-S1_W:0] s1_top;
    logic [ADDR_W-S2_W-1:0] s2_top;

    // Slice the bits that must agree or be zero.
    always_comb begin
        s1_top = addr[ADDR_W-1:S1_W-1];
        s2_top = addr[ADDR_W-1:S2_W];
        s1_ok  = (s1_top == '0) || (s1_top == '1);
        s2_ok  = (s2_top == '0);
    end
endmodule

// File: rtl/xlat_verdict.sv
// Combines span results per mode into a fault kind.
// Assumes one span checker per paging depth (3, 4, 5 levels).
module xlat_verdict
    import xlat_chk_pkg::*;
#(
    parameter int N_DEPTH   = 3,
    parameter int MIN_LEVEL = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              stage2,
    input  logic [2:0]        mode,
    output logic [1:0]        kind
);
    logic [N_DEPTH-1:0] s1_ok, s2_ok;

    genvar g;
    generate
        for (g = 0; g < N_DEPTH; g++) begin : g_span
            xlat_span_chk #(.LEVELS(MIN_LEVEL + g)) u_span (
                .addr  (addr),
                .s1_ok (s1_ok[g]),
                .s2_ok (s2_ok[g])
            );
        end
    endgenerate

    logic legal;
    logic [2:0] depth_idx;

    // Select the span result for the requested mode.
    always_comb begin
        legal     = 1'b0;
        depth_idx = mode - 3'd1;
        if (mode == MD_BARE32)
            legal = 1'b1;
        else if (int'(mode) <= N_DEPTH)
            legal = stage2 ? s2_ok[depth_idx] : s1_ok[depth_idx];
        kind = legal ? FK_NONE : (stage2 ? FK_GUEST : FK_PAGE);
    end
endmodule

// File: rtl/xlat_range_chk.sv
// Top: accepts one request at a time, registers the verdict, holds it
// until consumed. Synchronous active-low reset.
module xlat_range_chk
    import xlat_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_addr,
    input  logic        req_stage2,
    input  logic [2:0]  req_mode,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic        rsp_fault,
    output logic [1:0]  rsp_kind
);
    logic [1:0] kind_c;
    logic       accept;

    xlat_verdict #(.N_DEPTH(3), .MIN_LEVEL(3)) u_verdict (
        .addr   (req_addr),
        .stage2 (req_stage2),
        .mode   (req_mode),
        .kind   (kind_c)
    );

    // Ready while no verdict is waiting.
    assign req_ready = !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign rsp_fault = (rsp_kind != FK_NONE);

    // Capture verdict on accept, release on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= FK_NONE;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_kind  <= kind_c;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R2
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R2
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind)));
    // R2
    no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R9
    undef_mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode[2]) |=> (rsp_kind != FK_NONE));
    // R7
    bare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == MD_BARE32) |=> (rsp_kind == FK_NONE));
    // R10
    kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'b11));
endmodule

// File: tb/tb_xlat_range_chk.sv
module tb_xlat_range_chk;
    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_stage2 = 0, rsp_ready = 0;
    logic [63:0] req_addr = '0;
    logic [2:0] req_mode = '0;
    logic req_ready, rsp_valid, rsp_fault;
    logic [1:0] rsp_kind;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    xlat_range_chk dut (.*);

    // Behavioural reference: returns expected kind.
    function automatic logic [1:0] ref_kind(logic [63:0] a, logic s2, logic [2:0] m);
        int w;
        logic ok;
        if (m == 0) return 2'b00;
        if (m > 3) return s2 ? 2'b10 : 2'b01;
        w = 12 + 9 * (int'(m) + 2) + (s2 ? 2 : 0);
        ok = 1;
        for (int i = 63; i >= w; i--) begin
            if (s2 && a[i]) ok = 0;
            if (!s2 && a[i] != a[w-1]) ok = 0;
        end
        if (!s2 && a[w-1] != a[63]) ok = 0;
        return ok ? 2'b00 : (s2 ? 2'b10 : 2'b01);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request, consume it, compare with the model.
    task automatic run(input string req, input logic [63:0] a, input logic s2, input logic [2:0] m);
        logic [1:0] e;
        e = ref_kind(a, s2, m);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_stage2 = s2; req_mode = m; rsp_ready = 1;
        chk({req, " ready"}, req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        chk({req, " rsp_valid"}, rsp_valid, 1);
        chk({req, " kind"}, rsp_kind, e);
        chk("R10 fault flag", rsp_fault, e != 2'b00);
        @(negedge clk);
        rsp_ready = 0;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 req_ready", req_ready, 1);

        run("R3 legal pos", 64'h0000_003F_FFFF_F000, 0, 1);
        run("R3 legal neg", 64'hFFFF_FFC0_0000_0000, 0, 1);
        run("R3 bit39", 64'h0000_0080_0000_0000, 0, 1);
        run("R3 bit38 only", 64'h0000_0040_0000_0000, 0, 1);
        run("R4 sv48 ok", 64'hFFFF_8000_0000_0000, 0, 2);
        run("R4 sv48 bad", 64'h0000_8000_0000_0000, 0, 2);
        run("R4 sv57 ok", 64'h00FF_FFFF_FFFF_FFFF, 0, 3);
        run("R4 sv57 bad", 64'h0100_0000_0000_0000, 0, 3);
        run("R5 allones", 64'hFFFF_FFFF_FF01_0000, 1, 1);
        run("R5 top in", 64'h0000_01FF_FFFF_FFFF, 1, 1);
        run("R5 bit41", 64'h0000_0200_0000_0000, 1, 1);
        run("R6 x4 48 ok", 64'h0003_FFFF_FFFF_FFFF, 1, 2);
        run("R6 x4 48 bad", 64'h0004_0000_0000_0000, 1, 2);
        run("R6 x4 57 ok", 64'h07FF_FFFF_FFFF_FFFF, 1, 3);
        run("R6 x4 57 bad", 64'h0800_0000_0000_0000, 1, 3);
        run("R7 s1", 64'hDEAD_BEEF_0000_1234, 0, 0);
        run("R7 s2", 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
        run("R8 low12 s1", 64'h0000_0000_0000_0FFF, 0, 1);
        run("R8 low12 s2", 64'h0000_0000_0000_0ABC, 1, 3);
        for (int m = 4; m < 8; m++) begin
            run("R9 s1", 64'h0, 0, 3'(m));
            run("R9 s2", 64'h0, 1, 3'(m));
        end

        // R2: hold the response while rsp_ready is low.
        @(negedge clk);
        req_valid = 1; req_addr = 64'h0000_0080_0000_0000; req_stage2 = 0; req_mode = 1; rsp_ready = 0;
        @(negedge clk);
        req_addr = 64'h0; req_mode = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R2 held valid", rsp_valid, 1);
            chk("R2 held kind", rsp_kind, 2'b01);
            chk("R2 not ready", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 0; rsp_ready = 1;
        @(negedge clk);
        chk("R2 released", rsp_valid, 0);
        rsp_ready = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule